// File: doc/BRIEF.md
# Persistence-Filtered Threshold Interrupt

This block watches the stream of completed clear-channel conversions from a light-sensing front end and raises an interrupt only when the reading has stayed outside a programmable window for long enough. Each conversion arrives as a one-cycle done pulse together with its 16-bit result. The block compares that result against a low bound and a high bound. A saturating counter tracks how many out-of-window results have arrived in a row. A 4-bit persistence code selects how many such results are needed, using a nonlinear scale.

When the required run is reached, a sticky status flag is set. The flag stays set until the command decoder sends a one-cycle clear strobe. An active-low interrupt pin follows the flag, but only while the interrupt enable is high. The enable only gates the pin and has no effect on the flag. Only the clear channel is fed in; the colour channels never reach this block.

Top module: `pers_thresh_irq`

## Requirements
- R1: A result is out of range when it is strictly below `thr_lo` or strictly above `thr_hi`; a result equal to either bound is in range.
- R2: The persistence code maps to a required run length as follows. Codes 0, 1, 2 and 3 require 0, 1, 2 and 3 results. Each code from 4 to 15 requires five times (code − 3), which gives 5, 10, … 60.
- R3: On a done pulse whose out-of-range result brings the consecutive count to the required run, `irq_status` reads 1 from the clock edge that samples the pulse.
- R4: An in-range result resets the consecutive count to zero, so a broken run must restart from the beginning.
- R5: With persistence code 0, every done pulse sets `irq_status`, whether the result is in range or out of range.
- R6: `irq_status` stays at 1 until a cycle with `irq_clr` high, and reads 0 after that edge. If a setting result arrives in the same cycle as `irq_clr`, the flag stays set.
- R7: The count saturates at the required run. After a clear, each further out-of-range result sets `irq_status` again at once, with no new run needed.
- R8: `irq_n` is 0 exactly when `irq_status` is 1 and `irq_en` is 1. `irq_en` never changes `irq_status`.
- R9: A change of `pers_code`, `thr_lo` or `thr_hi` resets the consecutive count to zero. A done pulse in the same cycle as such a change is discarded.
- R10: After reset, `irq_status` is 0 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_done | input | 1 | One-cycle pulse marking a finished clear-channel conversion |
| conv_value | input | 16 | Clear-channel result valid with `conv_done` |
| thr_lo | input | 16 | Low bound of the in-range window |
| thr_hi | input | 16 | High bound of the in-range window |
| pers_code | input | 4 | Persistence code selecting the required run length |
| irq_en | input | 1 | Interrupt pin enable |
| irq_clr | input | 1 | One-cycle clear strobe from the command decoder |
| irq_status | output | 1 | Sticky interrupt status flag |
| irq_n | output | 1 | Interrupt pin, active low |

## Verification
The assertions assume that `irq_clr` and `conv_done` are single-cycle strobes. They also assume that configuration inputs are held steady through reset, so the first cycle after release does not hide a change. The stimulus drives every input at the falling edge. It changes the thresholds or the persistence code only on cycles without a done pulse, and it issues clears as isolated strobes, except in the one case that deliberately overlaps a clear with a setting result. Every persistence code is swept with runs of alternating low-side and high-side violations, broken runs, and results placed exactly on the bounds.

// File: rtl/pfi_pkg.sv
package pfi_pkg;

   // Run length required by a persistence code: linear up to lin_max,
   // then a fixed step per code above it.
   function automatic int unsigned pers_required(input int unsigned code,
                                                 input int unsigned lin_max,
                                                 input int unsigned step);
      if (code <= lin_max)
         return code;
      return (code - lin_max) * step;
   endfunction

   function automatic int unsigned bits_for(input int unsigned v);
      int unsigned b;
      b = 1;
      while ((1 << b) <= v)
         b++;
      return b;
   endfunction

endpackage

// File: rtl/pfi_range_cmp.sv
module pfi_range_cmp #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] value,
   input  logic [DATA_W-1:0] bound_lo,
   input  logic [DATA_W-1:0] bound_hi,
   output logic              outside
);
   logic below_w;
   logic above_w;

   assign below_w = value < bound_lo;
   assign above_w = value > bound_hi;
   assign outside = below_w | above_w;
endmodule

// File: rtl/pfi_cfg_watch.sv
module pfi_cfg_watch #(
   parameter int DATA_W = 16,
   parameter int CODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] lo_in,
   input  logic [DATA_W-1:0] hi_in,
   input  logic [CODE_W-1:0] code_in,
   output logic              changed
);
   localparam int SNAP_W = 2 * DATA_W + CODE_W;

   logic [SNAP_W-1:0] snap_now;
   logic [SNAP_W-1:0] snap_q;

   assign snap_now = {lo_in, hi_in, code_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         snap_q <= '0;
      else
         snap_q <= snap_now;
   end

   assign changed = snap_now != snap_q;
endmodule

// File: rtl/pfi_persist.sv
module pfi_persist #(
   parameter int CODE_W  = 4,
   parameter int LIN_MAX = 3,
   parameter int STEP    = 5,
   parameter int CNT_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic              outside,
   input  logic              cfg_changed,
   input  logic [CODE_W-1:0] code,
   output logic              hit
);
   localparam int NCODES = 1 << CODE_W;

   logic [CNT_W-1:0] req_tab [NCODES];
   logic [CNT_W-1:0] req;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;

   for (genvar g = 0; g < NCODES; g++) begin : g_tab
      assign req_tab[g] = CNT_W'(pfi_pkg::pers_required(g, LIN_MAX, STEP));
   end

   assign req = req_tab[code];

   always_comb begin
      cnt_nxt = '0;
      if (outside)
         cnt_nxt = (cnt_q < req) ? cnt_q + CNT_W'(1) : cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (cfg_changed)
         cnt_q <= '0;
      else if (done)
         cnt_q <= cnt_nxt;
   end

   assign hit = done & ~cfg_changed & (cnt_nxt == req);
endmodule

// File: rtl/pfi_irq_out.sv
module pfi_irq_out #(
   parameter bit PIN_ACTIVE_LOW = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic clr,
   input  logic en,
   output logic status,
   output logic pin
);
   logic status_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         status_q <= 1'b0;
      else if (hit)
         status_q <= 1'b1;
      else if (clr)
         status_q <= 1'b0;
   end

   assign status = status_q;

   if (PIN_ACTIVE_LOW) begin : g_low
      assign pin = ~(status_q & en);
   end else begin : g_high
      assign pin = status_q & en;
   end
endmodule

// File: rtl/pers_thresh_irq.sv
module pers_thresh_irq #(
   parameter int DATA_W         = 16,
   parameter int CODE_W         = 4,
   parameter int LIN_MAX        = 3,
   parameter int STEP           = 5,
   parameter bit PIN_ACTIVE_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_done,
   input  logic [DATA_W-1:0] conv_value,
   input  logic [DATA_W-1:0] thr_lo,
   input  logic [DATA_W-1:0] thr_hi,
   input  logic [CODE_W-1:0] pers_code,
   input  logic              irq_en,
   input  logic              irq_clr,
   output logic              irq_status,
   output logic              irq_n
);
   localparam int MAX_REQ = int'(pfi_pkg::pers_required((1 << CODE_W) - 1, LIN_MAX, STEP));
   localparam int CNT_W   = int'(pfi_pkg::bits_for(MAX_REQ));

   if (DATA_W < 1 || DATA_W > 32) begin : g_bad_data
      $error("DATA_W out of supported range");
   end
   if (CODE_W < 1 || CODE_W > 6) begin : g_bad_code
      $error("CODE_W out of supported range");
   end
   if (STEP < 1) begin : g_bad_step
      $error("STEP must be positive");
   end

   logic outside_w;
   logic changed_w;
   logic hit_w;

   pfi_range_cmp #(.DATA_W(DATA_W)) u_cmp (
      .value    (conv_value),
      .bound_lo (thr_lo),
      .bound_hi (thr_hi),
      .outside  (outside_w)
   );

   pfi_cfg_watch #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_watch (
      .clk     (clk),
      .rst_n   (rst_n),
      .lo_in   (thr_lo),
      .hi_in   (thr_hi),
      .code_in (pers_code),
      .changed (changed_w)
   );

   pfi_persist #(
      .CODE_W  (CODE_W),
      .LIN_MAX (LIN_MAX),
      .STEP    (STEP),
      .CNT_W   (CNT_W)
   ) u_pers (
      .clk         (clk),
      .rst_n       (rst_n),
      .done        (conv_done),
      .outside     (outside_w),
      .cfg_changed (changed_w),
      .code        (pers_code),
      .hit         (hit_w)
   );

   pfi_irq_out #(.PIN_ACTIVE_LOW(PIN_ACTIVE_LOW)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit    (hit_w),
      .clr    (irq_clr),
      .en     (irq_en),
      .status (irq_status),
      .pin    (irq_n)
   );
endmodule

// File: rtl/pfi_checker.sv
module pfi_checker #(
   parameter int DATA_W         = 16,
   parameter int CODE_W         = 4,
   parameter bit PIN_ACTIVE_LOW = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              conv_done,
   input logic [DATA_W-1:0] conv_value,
   input logic [DATA_W-1:0] thr_lo,
   input logic [DATA_W-1:0] thr_hi,
   input logic [CODE_W-1:0] pers_code,
   input logic              irq_en,
   input logic              irq_clr,
   input logic              irq_status,
   input logic              irq_n
);
   logic pin_on;
   assign pin_on = PIN_ACTIVE_LOW ? ~irq_n : irq_n;

   assert_pin_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !pin_on);

   assert_pin_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en && irq_status) |-> pin_on);

   assert_rise_needs_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_status) |-> $past(conv_done));

   assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_status && !irq_clr) |=> irq_status);

   assert_fall_needs_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_status) |-> $past(irq_clr));

   assert_code_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && pers_code == '0 && $past(rst_n) && $stable(pers_code)
       && $stable(thr_lo) && $stable(thr_hi)) |=> irq_status);

   assert_reset_R10: assert property (@(posedge clk)
      !rst_n |=> !irq_status);
endmodule

bind pers_thresh_irq pfi_checker #(
   .DATA_W(DATA_W), .CODE_W(CODE_W), .PIN_ACTIVE_LOW(PIN_ACTIVE_LOW)
) u_chk (.*);

// File: tb/sim_pers_thresh_irq.sv
`timescale 1ns/1ps
module sim_pers_thresh_irq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        conv_done = 1'b0;
   logic [15:0] conv_value = '0;
   logic [15:0] thr_lo = 16'd100;
   logic [15:0] thr_hi = 16'd200;
   logic [3:0]  pers_code = '0;
   logic        irq_en = 1'b1;
   logic        irq_clr = 1'b0;
   logic        irq_status;
   logic        irq_n;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   pers_thresh_irq u0 (.*);

   function automatic int need(input int code);
      case (code)
         0: return 0;   1: return 1;   2: return 2;   3: return 3;
         4: return 5;   5: return 10;  6: return 15;  7: return 20;
         8: return 25;  9: return 30;  10: return 35; 11: return 40;
         12: return 45; 13: return 50; 14: return 55; default: return 60;
      endcase
   endfunction

   // Alternate low-side and high-side violations
   function automatic logic [15:0] bad_val(input int i);
      if (i % 2 == 0)
         return 16'(99 - (i % 90));
      return 16'(201 + i * 37);
   endfunction

   task automatic chk(input string tag, input logic exp_status);
      logic exp_pin;
      exp_pin = ~(exp_status & irq_en);
      n_chk++;
      if (irq_status !== exp_status || irq_n !== exp_pin) begin
         n_err++;
         $display("FAIL %s: actual status=%0b pin=%0b expected status=%0b pin=%0b",
                  tag, irq_status, irq_n, exp_status, exp_pin);
      end
   endtask

   task automatic pulse(input logic [15:0] v, input logic with_clr);
      @(negedge clk);
      conv_done = 1'b1; conv_value = v; irq_clr = with_clr;
      @(negedge clk);
      conv_done = 1'b0; irq_clr = 1'b0;
   endtask

   task automatic clear_irq();
      @(negedge clk); irq_clr = 1'b1;
      @(negedge clk); irq_clr = 1'b0;
   endtask

   task automatic set_code(input int c);
      @(negedge clk); pers_code = 4'(c);
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual running expected done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 during reset", 1'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R10 after reset", 1'b0);

      // Sweep every persistence code
      for (int c = 0; c < 16; c++) begin
         int n;
         n = need(c);
         set_code(c);
         clear_irq();
         chk("R6 clear before sweep", 1'b0);
         if (n == 0) begin
            pulse(16'd150, 1'b0);
            chk("R5 in-range sets with code 0", 1'b1);
            clear_irq();
            pulse(16'd5, 1'b0);
            chk("R5 out-of-range sets with code 0", 1'b1);
         end else begin
            for (int i = 0; i < n - 1; i++) begin
               pulse(bad_val(i), 1'b0);
               chk("R2 short run stays clear", 1'b0);
            end
            pulse((c % 2 == 0) ? 16'd100 : 16'd200, 1'b0);
            chk("R1 R4 bound value breaks run", 1'b0);
            for (int i = 0; i < n - 1; i++) begin
               pulse(bad_val(i + 1), 1'b0);
               chk("R4 restarted run stays clear", 1'b0);
            end
            pulse(bad_val(n), 1'b0);
            chk("R2 R3 run reaches required length", 1'b1);
            pulse(16'd150, 1'b0);
            chk("R6 flag holds over in-range result", 1'b1);
            clear_irq();
            chk("R6 clear strobe", 1'b0);
            pulse(16'd150, 1'b0);
            chk("R4 in-range after run", 1'b0);
            for (int i = 0; i < n; i++) pulse(bad_val(i), 1'b0);
            chk("R3 second full run", 1'b1);
            clear_irq();
            pulse(16'd60000, 1'b0);
            chk("R7 saturated count retriggers", 1'b1);
         end
      end

      // R1: values one step outside each bound with code 1
      set_code(1);
      clear_irq();
      pulse(16'd100, 1'b0); chk("R1 equal low bound in range", 1'b0);
      pulse(16'd200, 1'b0); chk("R1 equal high bound in range", 1'b0);
      pulse(16'd99, 1'b0);  chk("R1 below low bound", 1'b1);
      clear_irq();
      pulse(16'd201, 1'b0); chk("R1 above high bound", 1'b1);

      // R6: setting result in the same cycle as clear
      clear_irq();
      pulse(16'd0, 1'b1);
      chk("R6 set wins over clear", 1'b1);

      // R8: enable gates only the pin
      clear_irq();
      @(negedge clk); irq_en = 1'b0;
      pulse(16'd0, 1'b0);
      chk("R8 status sets with enable low", 1'b1);
      @(negedge clk); irq_en = 1'b1; #1;
      chk("R8 pin follows enable", 1'b1);

      // R9: threshold change resets the run (code 4 needs 5)
      set_code(4);
      clear_irq();
      for (int i = 0; i < 4; i++) pulse(16'd250, 1'b0);
      chk("R9 partial run", 1'b0);
      @(negedge clk); thr_hi = 16'd220;
      @(negedge clk);
      for (int i = 0; i < 4; i++) pulse(16'd250, 1'b0);
      chk("R9 run restarted after threshold change", 1'b0);
      pulse(16'd250, 1'b0);
      chk("R9 full run after threshold change", 1'b1);

      // R9: code change resets the run (5 then 10 needed)
      clear_irq();
      set_code(0);
      set_code(4);
      clear_irq();
      for (int i = 0; i < 4; i++) pulse(16'd10, 1'b0);
      set_code(5);
      for (int i = 0; i < 9; i++) pulse(16'd10, 1'b0);
      chk("R9 run restarted after code change", 1'b0);
      pulse(16'd10, 1'b0);
      chk("R9 full run after code change", 1'b1);

      // R9: done coincident with a change is discarded (code 1)
      set_code(1);
      clear_irq();
      @(negedge clk);
      thr_lo = 16'd120; conv_done = 1'b1; conv_value = 16'd5;
      @(negedge clk);
      conv_done = 1'b0;
      chk("R9 done during change discarded", 1'b0);
      pulse(16'd5, 1'b0);
      chk("R9 next done counted", 1'b1);

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule